// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of an 8-bit voltage DAC that is loaded over a three-wire serial link: an active-low frame select, a serial clock and a data line. All three lines are oversampled in the system clock domain. Each line passes through a two-flop synchronizer, and the edges of each line are found by comparing it with its previous sampled value.

A frame opens when the select line falls. A data bit is taken on every falling edge of the serial clock, most significant bit first. On the sixteenth falling edge the received word is committed. This does not wait for the select line to return high. The commit loads an 8-bit conversion code and a 2-bit output-stage mode. The mode is decoded into three enables for the analog output stage: a strong (1 kΩ) pulldown, a weak (100 kΩ) pulldown and a high-impedance output.

The ideal analog level is the supply voltage times code/256, with straight binary coding. The analog stage itself lies outside this block.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset the code output is 0, the mode output is 00 (normal run) and all three termination enables are low.
- R2: A frame starts only on a falling edge of the synchronized select line. Bits are sampled on falling edges of the serial clock, and the first bit received is word bit 15.
- R3: In the committed 16-bit word, bits 13:12 form the mode and bits 11:4 form the code (bit 11 is the code MSB). Bits 15:14 and 3:0 have no effect on any output.
- R4: The code and mode take their new values on the 16th falling serial-clock edge of a frame, even if select stays low.
- R5: Mode 00 drives no enable. Mode 01 drives only the strong-pulldown enable, 10 only the weak-pulldown enable, and 11 only the high-impedance enable. At most one enable is ever high.
- R6: If select rises before 16 bits have arrived, the partial frame is dropped and the code and mode keep their previous values.
- R7: Serial-clock falling edges after the 16th bit, while select is still low, are ignored. No further frame is accepted until select goes high and then falls again.
- R8: The outputs change on the third system clock edge after the 16th serial-clock fall is applied at the input: two synchronizer stages, then the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSelN | input | 1 | Active-low frame select (asynchronous) |
| serClk | input | 1 | Serial clock; idles high (asynchronous) |
| serData | input | 1 | Serial data, sampled on serClk falls |
| codeOut | output | 8 | Committed conversion code |
| modeOut | output | 2 | Committed output-stage mode |
| pullStrongEn | output | 1 | Enable for the 1 kΩ pulldown |
| pullWeakEn | output | 1 | Enable for the 100 kΩ pulldown |
| outHiZ | output | 1 | Output high-impedance enable |

## Verification
The hardest case to reach from the ports is a frame that is still open after its 16th bit. Select stays low while the serial clock keeps toggling with new data, and a whole second word is then clocked in without select ever rising. Directed sequences hold select low after a commit and shift in both extra edges and a full second frame. Random frames also vary the bit count below, at and above sixteen, and choose per frame whether select is released. The bench model commits only frames that reach sixteen bits after a fresh select fall.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CODE_W     = 8;
  localparam int CODE_LSB   = 4;
  localparam int MODE_LSB   = 12;
  localparam int MODE_W     = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN    = 2'b00,
    MODE_PD_LO  = 2'b01,
    MODE_PD_HI  = 2'b10,
    MODE_HIZ    = 2'b11
  } outMode_t;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/sdac_rx_ctrl.sv
module sdac_rx_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_BITS    = FRAME_BITS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selNIn,
  input  logic       sclkIn,
  input  logic       dinIn,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(NUM_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(NUM_BITS - 1);

  logic [SYNC_STAGES-1:0] selPipe, sclkPipe, dinPipe;
  logic selNow, sclkNow, dinNow;
  logic selPrev, sclkPrev;
  logic active;
  logic [CNT_W-1:0] bitCnt;
  logic selFall, sclkFall;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selPipe  <= '1;
          sclkPipe <= '1;
          dinPipe  <= '0;
        end else begin
          selPipe  <= {selPipe[SYNC_STAGES-2:0], selNIn};
          sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
          dinPipe  <= {dinPipe[SYNC_STAGES-2:0], dinIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selPipe  <= '1;
          sclkPipe <= '1;
          dinPipe  <= '0;
        end else begin
          selPipe  <= selNIn;
          sclkPipe <= sclkIn;
          dinPipe  <= dinIn;
        end
      end
    end
  endgenerate

  assign selNow  = selPipe[SYNC_STAGES-1];
  assign sclkNow = sclkPipe[SYNC_STAGES-1];
  assign dinNow  = dinPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      selPrev  <= selNow;
      sclkPrev <= sclkNow;
    end
  end

  assign selFall  = selPrev & ~selNow;
  assign sclkFall = sclkPrev & ~sclkNow;

  always_comb begin
    strb         = '0;
    strb.bitVal  = dinNow;
    strb.shiftEn = active & ~selNow & ~selFall & sclkFall;
    strb.commit  = strb.shiftEn & (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (selNow) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (selFall) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (strb.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) active <= 1'b0;
    end
  end

  // R6: a high select closes any open frame on the next edge
  p_abort_on_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    selNow |=> !active);
  // R7: after a commit the frame stays closed
  p_close_after_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !active);
  // R2: a frame opens with an empty bit count
  p_clean_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (bitCnt == '0));
endmodule

// File: rtl/sdac_rx_dpath.sv
module sdac_rx_dpath
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  output logic [CODE_W-1:0] codeReg,
  output outMode_t          modeReg,
  output logic              pullStrongEn,
  output logic              pullWeakEn,
  output logic              outHiZ
);
  // Only word bits up to the top of the mode field are kept; bit 0 arrives
  // with the commit strobe itself.
  localparam int KEEP_W = MODE_LSB + MODE_W - 1;

  logic [KEEP_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.shiftEn) begin
      shReg <= {shReg[KEEP_W-2:0], strb.bitVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
      modeReg <= MODE_RUN;
    end else if (strb.commit) begin
      codeReg <= shReg[CODE_LSB-1 +: CODE_W];
      modeReg <= outMode_t'(shReg[MODE_LSB-1 +: MODE_W]);
    end
  end

  always_comb begin
    pullStrongEn = 1'b0;
    pullWeakEn   = 1'b0;
    outHiZ       = 1'b0;
    unique case (modeReg)
      MODE_PD_LO: pullStrongEn = 1'b1;
      MODE_PD_HI: pullWeakEn   = 1'b1;
      MODE_HIZ:   outHiZ       = 1'b1;
      default:    ;
    endcase
  end

  // R6: code and mode move only on a commit strobe
  p_hold_without_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(codeReg) && $stable(modeReg)));
  // R5: terminations never overlap
  p_single_term_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pullStrongEn, pullWeakEn, outHiZ}));
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSelN,
  input  logic       serClk,
  input  logic       serData,
  output logic [7:0] codeOut,
  output logic [1:0] modeOut,
  output logic       pullStrongEn,
  output logic       pullWeakEn,
  output logic       outHiZ
);
  rxStrobe_t strb;
  outMode_t  modeReg;

  sdac_rx_ctrl #(.SYNC_STAGES(2), .NUM_BITS(FRAME_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .selNIn (frameSelN),
    .sclkIn (serClk),
    .dinIn  (serData),
    .strb   (strb)
  );

  sdac_rx_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .codeReg      (codeOut),
    .modeReg      (modeReg),
    .pullStrongEn (pullStrongEn),
    .pullWeakEn   (pullWeakEn),
    .outHiZ       (outHiZ)
  );

  assign modeOut = modeReg;
endmodule

// File: tb/sim_sdac_cmd_rx.sv
module sim_sdac_cmd_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSelN = 1'b1;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic [7:0] codeOut;
  logic [1:0] modeOut;
  logic pullStrongEn, pullWeakEn, outHiZ;

  int total = 0;
  int bad = 0;
  logic [7:0] expCode = 8'h00;
  logic [1:0] expMode = 2'b00;
  int unsigned seedDummy;

  always #4 clk = ~clk;

  sdac_cmd_rx u0 (
    .clk(clk), .rstN(rstN), .frameSelN(frameSelN), .serClk(serClk),
    .serData(serData), .codeOut(codeOut), .modeOut(modeOut),
    .pullStrongEn(pullStrongEn), .pullWeakEn(pullWeakEn), .outHiZ(outHiZ)
  );

  function automatic logic [2:0] termOf(input logic [1:0] m);
    case (m)
      2'b01:   return 3'b100;
      2'b10:   return 3'b010;
      2'b11:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [12:0] expVec();
    return {expCode, expMode, termOf(expMode)};
  endfunction

  task automatic checkOut(input string tag);
    logic [12:0] act;
    act = {codeOut, modeOut, pullStrongEn, pullWeakEn, outHiZ};
    total++;
    if (act !== expVec()) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expVec());
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic openFrame();
    @(negedge clk); frameSelN = 1'b1; hold(3);
    frameSelN = 1'b0; hold(3);
  endtask

  task automatic shiftBits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      serData = (i < 16) ? w[15-i] : 1'($urandom);
      serClk = 1'b1; hold(3);
      serClk = 1'b0; hold(3);
    end
    serClk = 1'b1; hold(3);
  endtask

  task automatic commitModel(input logic [15:0] w);
    expCode = w[11:4];
    expMode = w[13:12];
  endtask

  task automatic fullFrame(input logic [15:0] w, input bit release_);
    openFrame();
    shiftBits(w, 16);
    commitModel(w);
    if (release_) begin frameSelN = 1'b1; hold(3); end
    hold(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    seedDummy = $urandom(32'h5EED_0042);
    hold(4);
    rstN = 1'b1;
    hold(2);
    checkOut("R1 reset state");

    // R2/R3/R5: each mode, with ignored bits set to ones
    fullFrame(16'b11_01_10100101_1111, 1); checkOut("R3 R5 mode 01 code A5");
    fullFrame(16'b11_10_01011010_1111, 1); checkOut("R3 R5 mode 10 code 5A");
    fullFrame(16'b00_11_11111111_0000, 1); checkOut("R5 mode 11 code FF");
    fullFrame(16'b00_00_10000000_0000, 1); checkOut("R2 msb first code 80");
    fullFrame(16'b11_00_00000001_1111, 1); checkOut("R3 ignored bits, code 01");

    // R4: commit without select release
    fullFrame(16'h2C30, 0); checkOut("R4 commit with select low");

    // R7: extra edges while select stays low
    shiftBits(16'hFFFF, 5); hold(4); checkOut("R7 extra edges ignored");
    shiftBits(16'h3AB0, 16); hold(4); checkOut("R7 second word without reselect ignored");
    frameSelN = 1'b1; hold(3);

    // R6: partial frames dropped
    openFrame(); shiftBits(16'h1F00, 15); frameSelN = 1'b1; hold(5);
    checkOut("R6 15-bit frame dropped");
    openFrame(); shiftBits(16'h3330, 3); frameSelN = 1'b1; hold(5);
    checkOut("R6 3-bit frame dropped");

    // R8: latency of the 16th edge
    w = 16'h1E70;
    openFrame();
    shiftBits(w, 15);
    serData = w[0]; serClk = 1'b1; hold(3);
    serClk = 1'b0;
    hold(2); checkOut("R8 unchanged two edges after last fall");
    commitModel(w);
    hold(1); checkOut("R8 updated on third edge");
    serClk = 1'b1; frameSelN = 1'b1; hold(4);

    // random frames
    for (int k = 0; k < 40; k++) begin
      int n;
      bit rel;
      w = 16'($urandom);
      case ($urandom % 4)
        0:       n = $urandom % 16;
        1:       n = 16 + ($urandom % 6);
        default: n = 16;
      endcase
      rel = 1'($urandom);
      openFrame();
      shiftBits(w, n);
      if (n >= 16) commitModel(w);
      if (rel || n < 16) begin frameSelN = 1'b1; hold(3); end
      hold(2);
      checkOut(n >= 16 ? "R2 R4 R7 random frame" : "R6 random partial frame");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule